// File: doc/BRIEF.md
# JTAG Test Access Port with Instruction Decode

This block is the test access port of a device. A standard sixteen-state controller runs on the test clock and walks the instruction and data scans. A five-bit instruction register picks which data path sits between the serial input and the serial output. Three paths are internal: a one-bit bypass stage, a fixed 32-bit identification word, and a 32-bit user-code word. Two more paths lead to user-supplied data registers, which receive a select line and capture, shift and update strobes.

The instruction decode also drives a global output-disable line for the high-impedance instruction. It raises one flag per instruction whose data path lies outside this block: external test, sample/preload, internal test, configuration read, configuration write and start-up clocking. While one of those is current, the serial path falls back to bypass. The serial output changes on the falling test-clock edge and is enabled only while a shift state is active.

Top module: `jtag_port`

## Requirements
- R1: The controller follows the standard sixteen-state sequence. Five rising edges with TMS high reach Test-Logic-Reset from any state. Pulling trst_n low forces Test-Logic-Reset at once and clears tdo_en at once.
- R2: Entering Test-Logic-Reset loads the identification instruction (01001). A data scan that follows returns the identification word, least significant bit first.
- R3: The identification word is, from bit 31 down, a 4-bit version (parameter), a 7-bit family field holding 03h, a 9-bit row-count field (parameter), an 11-bit company field holding 49h, and a 1 in bit 0. With version 0 and rows 010h it reads 00610093h.
- R4: Capture-IR loads 00001 into the instruction shift stage. That pattern leaves on TDO first during Shift-IR, least significant bit first.
- R5: A new instruction takes effect only on Update-IR. The codes are: external test 00000, sample 00001, user-1 00010, user-2 00011, configuration read 00100, configuration write 00101, internal test 00111, user code 01000, identification 01001, high-impedance 01010, start-up 01100 and bypass 11111.
- R6: Bypass and every unlisted code select the one-bit bypass stage. That stage captures 0, so TDO repeats TDI one shift later.
- R7: While the high-impedance instruction (01010) is current, out_disable is high and the serial path is bypass. Any other instruction leaves out_disable low.
- R8: The user-code instruction (01000) captures user_code when cfg_done is high and all ones when it is low.
- R9: User-1 (00010) and user-2 (00011) raise usr_sel1 or usr_sel2 respectively, never both. They route usr_tdo1 or usr_tdo2 to TDO. dr_capture, dr_shift and dr_update pulse in Capture-DR, Shift-DR and Update-DR only while one of these two instructions is current.
- R10: mode_flags has bit 0 for external test, bit 1 for sample, bit 2 for internal test, bit 3 for configuration read, bit 4 for configuration write and bit 5 for start-up. A bit is high while its instruction is current. These instructions use the bypass path.
- R11: TDO changes only on the falling TCK edge. tdo_en is high only in Shift-IR and Shift-DR, and TDO is high-impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| cfg_done | input | 1 | Configuration has completed |
| user_code | input | 32 | User identification value |
| usr_tdo1 | input | 1 | Serial output of user register 1 |
| usr_tdo2 | input | 1 | Serial output of user register 2 |
| tdo | output | 1 | Serial data out, high-impedance when not shifting |
| tdo_en | output | 1 | TDO driver enable |
| out_disable | output | 1 | Global output disable |
| usr_sel1 | output | 1 | User register 1 selected |
| usr_sel2 | output | 1 | User register 2 selected |
| dr_capture | output | 1 | User register capture strobe |
| dr_shift | output | 1 | User register shift strobe |
| dr_update | output | 1 | User register update strobe |
| mode_flags | output | 6 | Decoded out-of-block instruction flags |

## Verification
Controller state moves on the rising edge that samples TMS, so the select, strobe and decode outputs are valid from just after that edge. The bench samples them half a period later, at the falling edge. TDO is registered on the falling edge and shows the bit that the next rising edge shifts out. The bench therefore reads it just after the falling edge of each shift step and confirms that it has not moved just after the following rising edge. A new instruction shows on out_disable, the selects and mode_flags one edge after Update-IR, so those outputs are checked only once the scan is back in Run-Test/Idle.

// File: rtl/jtp_pkg.sv
package jtp_pkg;

  localparam int OP_W   = 5;
  localparam int FLAG_W = 6;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UP_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
  } tap_st_e;

  localparam logic [OP_W-1:0] OP_EXTEST  = 5'b00000;
  localparam logic [OP_W-1:0] OP_SAMPLE  = 5'b00001;
  localparam logic [OP_W-1:0] OP_USER1   = 5'b00010;
  localparam logic [OP_W-1:0] OP_USER2   = 5'b00011;
  localparam logic [OP_W-1:0] OP_CFG_RD  = 5'b00100;
  localparam logic [OP_W-1:0] OP_CFG_WR  = 5'b00101;
  localparam logic [OP_W-1:0] OP_INTEST  = 5'b00111;
  localparam logic [OP_W-1:0] OP_UCODE   = 5'b01000;
  localparam logic [OP_W-1:0] OP_IDCODE  = 5'b01001;
  localparam logic [OP_W-1:0] OP_HIGHZ   = 5'b01010;
  localparam logic [OP_W-1:0] OP_START   = 5'b01100;
  localparam logic [OP_W-1:0] OP_BYPASS  = 5'b11111;

  localparam logic [OP_W-1:0] IR_CAPTURE = 5'b00001;

  typedef enum logic [2:0] {
    PATH_BYP, PATH_ID, PATH_UC, PATH_U1, PATH_U2
  } dr_path_e;

  typedef struct packed {
    dr_path_e          path;
    logic              hiz;
    logic [FLAG_W-1:0] flags;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [OP_W-1:0] op);
    op_dec_t r;
    r.path  = PATH_BYP;
    r.hiz   = 1'b0;
    r.flags = '0;
    case (op)
      OP_EXTEST: r.flags[0] = 1'b1;
      OP_SAMPLE: r.flags[1] = 1'b1;
      OP_INTEST: r.flags[2] = 1'b1;
      OP_CFG_RD: r.flags[3] = 1'b1;
      OP_CFG_WR: r.flags[4] = 1'b1;
      OP_START:  r.flags[5] = 1'b1;
      OP_USER1:  r.path = PATH_U1;
      OP_USER2:  r.path = PATH_U2;
      OP_UCODE:  r.path = PATH_UC;
      OP_IDCODE: r.path = PATH_ID;
      OP_HIGHZ:  r.hiz  = 1'b1;
      default:   r.path = PATH_BYP;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/jtp_fsm.sv
module jtp_fsm
  import jtp_pkg::*;
(
  input  logic    tck,
  input  logic    rst_n,
  input  logic    tms,
  output tap_st_e state
);

  tap_st_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  state_d = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: state_d = tms ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  state_d = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: state_d = tms ? ST_UP_IR  : ST_SH_IR;
      ST_UP_IR:  state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= state_d;
  end

endmodule

// File: rtl/jtp_ir.sv
module jtp_ir
  import jtp_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_st_e         state,
  input  logic            tdi,
  output logic [OP_W-1:0] ir_q,
  output logic [OP_W-1:0] ir_sh
);

  logic [OP_W-1:0] ir_d, sh_d;
  logic            ir_en, sh_en;

  always_comb begin
    sh_en = 1'b0;
    sh_d  = ir_sh;
    if (state == ST_CAP_IR) begin
      sh_en = 1'b1;
      sh_d  = IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      sh_en = 1'b1;
      sh_d  = {tdi, ir_sh[OP_W-1:1]};
    end
  end

  always_comb begin
    ir_en = 1'b0;
    ir_d  = ir_q;
    if (state == ST_TLR) begin
      ir_en = 1'b1;
      ir_d  = OP_IDCODE;
    end else if (state == ST_UP_IR) begin
      ir_en = 1'b1;
      ir_d  = ir_sh;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_sh <= IR_CAPTURE;
    else if (sh_en) ir_sh <= sh_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_q <= OP_IDCODE;
    else if (ir_en) ir_q <= ir_d;
  end

endmodule

// File: rtl/jtp_dr.sv
module jtp_dr
  import jtp_pkg::*;
#(
  parameter int          DR_W    = 32,
  parameter logic [31:0] ID_WORD = 32'h0061_0093
)(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_st_e         state,
  input  dr_path_e        path,
  input  logic            tdi,
  input  logic            cfg_done,
  input  logic [DR_W-1:0] user_code,
  output logic            dr_lsb
);

  localparam logic [DR_W-1:0] ONES = '1;

  logic [DR_W-1:0] sr_q, sr_d;
  logic            sr_en;
  logic            wide;

  assign wide = (path == PATH_ID) || (path == PATH_UC);

  always_comb begin
    sr_en = 1'b0;
    sr_d  = sr_q;
    if (state == ST_CAP_DR) begin
      sr_en = 1'b1;
      case (path)
        PATH_ID: sr_d = ID_WORD[DR_W-1:0];
        PATH_UC: sr_d = cfg_done ? user_code : ONES;
        default: sr_d = '0;
      endcase
    end else if (state == ST_SH_DR) begin
      sr_en = 1'b1;
      if (wide) sr_d = {tdi, sr_q[DR_W-1:1]};
      else      sr_d[0] = tdi;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign dr_lsb = sr_q[0];

endmodule

// File: rtl/jtag_port.sv
module jtag_port
  import jtp_pkg::*;
#(
  parameter logic [3:0] ID_VERSION = 4'h0,
  parameter logic [8:0] ID_ROWS    = 9'h010
)(
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic              cfg_done,
  input  logic [31:0]       user_code,
  input  logic              usr_tdo1,
  input  logic              usr_tdo2,
  output logic              tdo,
  output logic              tdo_en,
  output logic              out_disable,
  output logic              usr_sel1,
  output logic              usr_sel2,
  output logic              dr_capture,
  output logic              dr_shift,
  output logic              dr_update,
  output logic [FLAG_W-1:0] mode_flags
);

  localparam int          DR_W    = 32;
  localparam logic [6:0]  FAMILY  = 7'h03;
  localparam logic [10:0] COMPANY = 11'h049;
  localparam logic [31:0] ID_WORD = {ID_VERSION, FAMILY, ID_ROWS, COMPANY, 1'b1};

  logic [1:0]      rst_sync;
  logic            rst_n;
  tap_st_e         state;
  logic [OP_W-1:0] ir_q, ir_sh;
  op_dec_t         dec;
  logic            dr_lsb;
  logic            tdo_src, tdo_q, tdo_oe, shifting, usr_any;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  jtp_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  jtp_ir u_ir (
    .tck   (tck),
    .rst_n (rst_n),
    .state (state),
    .tdi   (tdi),
    .ir_q  (ir_q),
    .ir_sh (ir_sh)
  );

  assign dec = decode_op(ir_q);

  jtp_dr #(.DR_W(DR_W), .ID_WORD(ID_WORD)) u_dr (
    .tck       (tck),
    .rst_n     (rst_n),
    .state     (state),
    .path      (dec.path),
    .tdi       (tdi),
    .cfg_done  (cfg_done),
    .user_code (user_code),
    .dr_lsb    (dr_lsb)
  );

  always_comb begin
    if (state == ST_SH_IR) tdo_src = ir_sh[0];
    else begin
      case (dec.path)
        PATH_U1: tdo_src = usr_tdo1;
        PATH_U2: tdo_src = usr_tdo2;
        default: tdo_src = dr_lsb;
      endcase
    end
  end

  assign shifting = (state == ST_SH_IR) || (state == ST_SH_DR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q  <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_q  <= tdo_src;
      tdo_oe <= shifting;
    end
  end

  assign tdo         = tdo_oe ? tdo_q : 1'bz;
  assign tdo_en      = tdo_oe;
  assign out_disable = dec.hiz;
  assign mode_flags  = dec.flags;
  assign usr_sel1    = (dec.path == PATH_U1);
  assign usr_sel2    = (dec.path == PATH_U2);
  assign usr_any     = usr_sel1 | usr_sel2;
  assign dr_capture  = usr_any && (state == ST_CAP_DR);
  assign dr_shift    = usr_any && (state == ST_SH_DR);
  assign dr_update   = usr_any && (state == ST_UP_DR);

endmodule

// File: rtl/jtag_port_chk.sv
module jtag_port_chk
  import jtp_pkg::*;
(
  input logic            tck,
  input logic            rst_n,
  input logic            tms,
  input tap_st_e         state,
  input logic [OP_W-1:0] ir_q,
  input logic [OP_W-1:0] ir_sh,
  input logic            tdo_en,
  input logic            out_disable,
  input logic            usr_sel1,
  input logic            usr_sel2,
  input logic            dr_shift
);

  logic [2:0] hi_run;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)          hi_run <= 3'd0;
    else if (!tms)       hi_run <= 3'd0;
    else if (hi_run < 5) hi_run <= hi_run + 3'd1;
  end

  p_five_tms_tlr_r1: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_run == 3'd5) |-> (state == ST_TLR));

  p_tlr_loads_id_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR) |=> (ir_q == OP_IDCODE));

  p_cap_ir_pattern_r4: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (ir_sh == IR_CAPTURE));

  p_update_ir_r5: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_UP_IR) |=> (ir_q == $past(ir_sh)));

  p_highz_disable_r7: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_UP_IR && ir_sh == OP_HIGHZ) |=> out_disable);

  p_user_sel_excl_r9: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({usr_sel1, usr_sel2}));

  p_user_shift_state_r9: assert property (@(posedge tck) disable iff (!rst_n)
    dr_shift |-> (state == ST_SH_DR));

  p_tdo_en_shift_r11: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == (state == ST_SH_IR || state == ST_SH_DR));

endmodule

bind jtag_port jtag_port_chk u_chk (
  .tck         (tck),
  .rst_n       (rst_n),
  .tms         (tms),
  .state       (state),
  .ir_q        (ir_q),
  .ir_sh       (ir_sh),
  .tdo_en      (tdo_en),
  .out_disable (out_disable),
  .usr_sel1    (usr_sel1),
  .usr_sel2    (usr_sel2),
  .dr_shift    (dr_shift)
);

// File: tb/sim_jtag_port.sv
module sim_jtag_port;

  localparam logic [3:0] VER  = 4'h2;
  localparam logic [8:0] ROWS = 9'h028;

  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic        cfg_done = 1'b0;
  logic [31:0] user_code = 32'hA5C3_1E0F;
  logic        usr_tdo1 = 1'b1;
  logic        usr_tdo2 = 1'b0;
  wire         tdo;
  logic        tdo_en, out_disable, usr_sel1, usr_sel2;
  logic        dr_capture, dr_shift, dr_update;
  logic [5:0]  mode_flags;

  int checks = 0;
  int fails = 0;
  int edge_bad = 0;
  int en_bad = 0;
  bit finished = 1'b0;
  logic s_cap, s_sh, s_upd, s_en;

  always #10 tck = ~tck;

  jtag_port #(.ID_VERSION(VER), .ID_ROWS(ROWS)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .cfg_done(cfg_done),
    .user_code(user_code), .usr_tdo1(usr_tdo1), .usr_tdo2(usr_tdo2),
    .tdo(tdo), .tdo_en(tdo_en), .out_disable(out_disable),
    .usr_sel1(usr_sel1), .usr_sel2(usr_sel2), .dr_capture(dr_capture),
    .dr_shift(dr_shift), .dr_update(dr_update), .mode_flags(mode_flags)
  );

  function automatic logic [31:0] id_word();
    return {VER, 7'h03, ROWS, 11'h049, 1'b1};
  endfunction

  // path kind: 0 bypass, 1 id, 2 user code, 3 user1, 4 user2
  function automatic int kind_of(input logic [4:0] c);
    case (c)
      5'b01001: return 1;
      5'b01000: return 2;
      5'b00010: return 3;
      5'b00011: return 4;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [5:0] flags_of(input logic [4:0] c);
    case (c)
      5'b00000: return 6'b000001;
      5'b00001: return 6'b000010;
      5'b00111: return 6'b000100;
      5'b00100: return 6'b001000;
      5'b00101: return 6'b010000;
      5'b01100: return 6'b100000;
      default:  return 6'b000000;
    endcase
  endfunction

  function automatic logic [31:0] expect_dr(input logic [4:0] c, input logic [31:0] din);
    case (kind_of(c))
      1: return id_word();
      2: return cfg_done ? user_code : 32'hFFFF_FFFF;
      3: return usr_tdo1 ? 32'hFFFF_FFFF : 32'h0;
      4: return usr_tdo2 ? 32'hFFFF_FFFF : 32'h0;
      default: return {din[30:0], 1'b0};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    #1;
    o = tdo;
    s_cap = dr_capture; s_sh = dr_shift; s_upd = dr_update; s_en = tdo_en;
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
    if (s_en && tdo !== o) edge_bad++;
  endtask

  task automatic ir_load(input logic [4:0] code, output logic [4:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, code[i], o);
      cap[i] = o;
      if (!s_en) en_bad++;
    end
    step(1, 0, o);
    if (s_en) en_bad++;
    step(0, 0, o);
  endtask

  task automatic dr_scan(input int n, input logic [31:0] din, output logic [31:0] dout,
                         output logic cap, output logic sh, output logic upd);
    logic o;
    dout = '0;
    sh = 1'b1;
    step(1, 0, o); step(0, 0, o);
    step(0, 0, o);
    cap = s_cap;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
      sh &= s_sh;
      if (!s_en) en_bad++;
    end
    step(1, 0, o);
    step(0, 0, o);
    upd = s_upd;
  endtask

  task automatic to_idle();
    logic o;
    for (int i = 0; i < 5; i++) step(1, 0, o);
    step(0, 0, o);
  endtask

  initial begin
    logic [4:0]  irc;
    logic [31:0] dout, din;
    logic        c, s, u, o;
    void'($urandom(32'h0000_5EED));

    repeat (3) @(posedge tck);
    #1;
    chk(!tdo_en && !out_disable && mode_flags == 0 && !usr_sel1 && !usr_sel2,
        "R11 reset outputs idle", {tdo_en, out_disable, mode_flags}, 0);
    trst_n = 1'b1;
    repeat (3) @(posedge tck);
    to_idle();

    // R2 R3: identification after reset
    dr_scan(32, 32'h1234_5678, dout, c, s, u);
    chk(dout == id_word(), "R2 R3 id after reset", dout, id_word());

    // R4: capture pattern, R6 bypass
    ir_load(5'b11111, irc);
    chk(irc == 5'b00001, "R4 capture-IR pattern", irc, 5'b00001);
    din = 32'h0000_00B5;
    dr_scan(8, din, dout, c, s, u);
    chk(dout[7:0] == {din[6:0], 1'b0}, "R6 bypass delay", dout[7:0], {din[6:0], 1'b0});
    chk(!c && !s && !u, "R9 strobes idle in bypass", {c, s, u}, 0);

    // R6 reserved code
    ir_load(5'b10110, irc);
    dr_scan(32, 32'hCAFE_F00D, dout, c, s, u);
    chk(dout == {32'hCAFE_F00D << 1}, "R6 reserved as bypass", dout, 32'hCAFE_F00D << 1);

    // R5: code shifted but not updated has no effect
    begin
      step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < 5; i++) step(i == 4, 1'(5'b01010 >> i), o);
      step(0, 0, o); step(0, 0, o); // pause-IR
      chk(!out_disable, "R5 no change before update", out_disable, 0);
      step(1, 0, o); step(1, 0, o); step(0, 0, o);
      chk(out_disable, "R5 change after update", out_disable, 1);
    end

    // R7 high-impedance
    ir_load(5'b01010, irc);
    chk(out_disable && mode_flags == 0, "R7 out_disable high", {out_disable, mode_flags}, 7'h40);
    dr_scan(8, 32'h0000_0033, dout, c, s, u);
    chk(dout[7:0] == 8'h66, "R7 bypass path", dout[7:0], 8'h66);
    ir_load(5'b11111, irc);
    chk(!out_disable, "R7 released by other op", out_disable, 0);

    // R8 user code
    ir_load(5'b01000, irc);
    cfg_done = 1'b0;
    dr_scan(32, 32'h0, dout, c, s, u);
    chk(dout == 32'hFFFF_FFFF, "R8 unconfigured ones", dout, 32'hFFFF_FFFF);
    cfg_done = 1'b1;
    dr_scan(32, 32'h0, dout, c, s, u);
    chk(dout == user_code, "R8 configured code", dout, user_code);

    // R9 user registers
    ir_load(5'b00010, irc);
    chk(usr_sel1 && !usr_sel2, "R9 select user1", {usr_sel1, usr_sel2}, 2'b10);
    dr_scan(8, 32'h0, dout, c, s, u);
    chk(dout[7:0] == 8'hFF && c && s && u, "R9 user1 path and strobes", {c, s, u, dout[7:0]}, 11'h7FF);
    ir_load(5'b00011, irc);
    chk(!usr_sel1 && usr_sel2, "R9 select user2", {usr_sel1, usr_sel2}, 2'b01);
    dr_scan(8, 32'hFF, dout, c, s, u);
    chk(dout[7:0] == 8'h00 && c && s && u, "R9 user2 path and strobes", {c, s, u, dout[7:0]}, 11'h700);

    // R10 flags
    foreach (irc[i]) ; // no-op
    begin
      logic [4:0] fl_codes [6] = '{5'b00000, 5'b00001, 5'b00111, 5'b00100, 5'b00101, 5'b01100};
      for (int k = 0; k < 6; k++) begin
        ir_load(fl_codes[k], irc);
        chk(mode_flags == flags_of(fl_codes[k]) && !out_disable, "R10 mode flag",
            mode_flags, flags_of(fl_codes[k]));
      end
      dr_scan(8, 32'h0000_0081, dout, c, s, u);
      chk(dout[7:0] == 8'h02, "R10 flagged op uses bypass", dout[7:0], 8'h02);
    end

    // R1 five TMS-high edges from random states
    for (int r = 0; r < 3; r++) begin
      ir_load(5'b11111, irc);
      for (int i = 0; i < 20; i++) step(1'($urandom % 2), 0, o);
      to_idle();
      chk(mode_flags == 0 && !usr_sel1 && !usr_sel2, "R1 R2 reset by TMS", mode_flags, 0);
      dr_scan(32, 32'h0, dout, c, s, u);
      chk(dout == id_word(), "R1 id after TMS reset", dout, id_word());
    end

    // R1 asynchronous reset mid-scan
    ir_load(5'b11111, irc);
    step(1, 0, o); step(0, 0, o); step(0, 0, o); step(0, 1, o);
    @(negedge tck);
    #5;
    trst_n = 1'b0;
    #1;
    chk(!tdo_en, "R1 trst clears tdo_en", tdo_en, 0);
    repeat (2) @(posedge tck);
    #1;
    trst_n = 1'b1;
    repeat (3) @(posedge tck);
    to_idle();
    dr_scan(32, 32'h0, dout, c, s, u);
    chk(dout == id_word(), "R1 id after trst", dout, id_word());

    // random instructions and data
    for (int r = 0; r < 40; r++) begin
      logic [4:0] code;
      code = 5'($urandom % 32);
      cfg_done = 1'($urandom % 2);
      din = $urandom;
      ir_load(code, irc);
      chk(irc == 5'b00001, "R4 capture pattern random", irc, 5'b00001);
      chk(out_disable == (code == 5'b01010) && mode_flags == flags_of(code),
          "R7 R10 decode random", {out_disable, mode_flags}, {code == 5'b01010, flags_of(code)});
      dr_scan(32, din, dout, c, s, u);
      chk(dout == expect_dr(code, din), "R5 R6 R8 R9 data path random", dout, expect_dr(code, din));
    end

    chk(edge_bad == 0, "R11 tdo moves only on falling edge", edge_bad, 0);
    chk(en_bad == 0, "R11 tdo_en tracks shift states", en_bad, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule